// File: doc/BRIEF.md
# Multi-Port Pin Bank Controller with Edge Interrupts

This block drives and samples a set of 8-pin ports from a simple synchronous register bus. Each port owns a window of eight registers at a fixed address stride. In those registers software selects, for every pin, one of four drive styles: input, push-pull, sink-only (drives low, floats on a 1) or source-only (drives high, floats on a 0). It also sets the output levels, reads the synchronized input levels, switches the internal pull-ups and arms edge interrupts. A pin's global number is its port index times 8 plus its position in the port.

Pad levels pass through a two-flop synchronizer. An enabled pin whose synchronized level moves in the selected direction (rising or falling) latches a bit in the port's event register. Software clears that bit by writing a 1 to it. Each port has its own interrupt line. The line is high while an enabled event is pending or while the port's force register is non-zero. A global control word at address 0 holds a block enable and read-only version and core-count fields. While the block enable is 0, no events latch and every interrupt line stays low.

Top module: `pinbank_ctrl`

## Requirements
- R1: After reset every pad output and output enable is 0, every pull-up is enabled, every interrupt line is low, every port register reads 0 and the block enable is 0.
- R2: Port p register o sits at word address 16 + 16·p + o. The offsets are 0 mode, 1 output data, 2 input data, 3 pull-off, 4 interrupt enable, 5 edge select, 6 event, 7 force. Read data appears one cycle after the address. A write reaches only the addressed register. Pad bit 8·p + n belongs to port p pin n.
- R3: Mode field bits [2n+1:2n] = 00 makes pin n an input: output enable 0, pad output 0.
- R4: Mode 01 (push-pull) drives the pad with the output data bit, output enable 1.
- R5: Mode 10 (sink-only) drives 0 when the data bit is 0 and disables the driver when it is 1.
- R6: Mode 11 (source-only) drives 1 when the data bit is 1 and disables the driver when it is 0.
- R7: Input data bit n reads the pad level after two synchronizer stages.
- R8: An enabled pin whose edge-select bit is 1 latches its event bit on a rising synchronized edge and ignores a falling one.
- R9: An enabled pin whose edge-select bit is 0 latches on a falling edge and ignores a rising one.
- R10: A pin whose interrupt-enable bit is 0 never sets its event bit.
- R11: Writing the event register clears exactly the bits written as 1. The port interrupt is high while any bit of (event AND enable) is set.
- R12: A non-zero force register holds the port interrupt high. A zero force register leaves the interrupt to the events.
- R13: A 1 in pull-off bit n turns pin n's pull-up control low.
- R14: Address 0 reads {version[15:9], core count[8:2], 0, enable[0]}. Version (5) and core count (1) ignore writes. With enable 0, no events latch and all interrupt lines are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Word address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| pad_in | input | NUM_PORTS·8 | Pad input levels |
| pad_out | output | NUM_PORTS·8 | Pad output levels |
| pad_oe | output | NUM_PORTS·8 | Pad driver enables |
| pad_pull_en | output | NUM_PORTS·8 | Pull-up enables |
| irq | output | NUM_PORTS | Interrupt line per port |

## Verification
A corrupted mode or data register shows on pad_out and pad_oe in the very next cycle. The bench compares those pads directly after every configuration write. A wrong edge-detector or event state shows about three cycles after a pad change, as a missing or spurious interrupt and a wrong event read-back. The bench waits out the synchronizer latency and checks both. A decode fault shows as a write landing in a neighbouring port or register, so the bench reads untouched registers back as well.

// File: rtl/pinbank_pkg.sv
package pinbank_pkg;
  typedef enum logic [1:0] {
    PM_INPUT  = 2'b00,
    PM_PUSH   = 2'b01,
    PM_SINK   = 2'b10,
    PM_SOURCE = 2'b11
  } pin_mode_e;

  typedef enum logic [2:0] {
    RG_MODE    = 3'd0,
    RG_DOUT    = 3'd1,
    RG_DIN     = 3'd2,
    RG_PULLOFF = 3'd3,
    RG_IEN     = 3'd4,
    RG_EDGE    = 3'd5,
    RG_EVENT   = 3'd6,
    RG_FORCE   = 3'd7
  } port_reg_e;
endpackage

// File: rtl/pinbank_sync.sv
module pinbank_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1_q;
  logic [W-1:0] stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= d;
      stage2_q <= stage1_q;
    end
  end

  assign q = stage2_q;
endmodule

// File: rtl/pinbank_port.sv
module pinbank_port
  import pinbank_pkg::*;
#(
  parameter int PINS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              blk_en,
  input  logic              wr_en,
  input  port_reg_e         reg_sel,
  input  logic [2*PINS-1:0] wdata,
  input  logic [PINS-1:0]   pin_lvl,
  output logic [2*PINS-1:0] rd_val,
  output logic [PINS-1:0]   pad_out,
  output logic [PINS-1:0]   pad_oe,
  output logic [PINS-1:0]   pad_pull_en,
  output logic [PINS-1:0]   ev_q,
  output logic [PINS-1:0]   ien_q,
  output logic              irq,
  output logic              force_any
);
  localparam int MW = 2 * PINS;

  logic [MW-1:0]   mode_q,    mode_d;
  logic [PINS-1:0] dout_q,    dout_d;
  logic [PINS-1:0] pulloff_q, pulloff_d;
  logic [PINS-1:0] ien_d;
  logic [PINS-1:0] edge_q,    edge_d;
  logic [PINS-1:0] ev_d;
  logic [PINS-1:0] force_q,   force_d;
  logic [PINS-1:0] prev_q;
  logic [PINS-1:0] rise, fall, hit, clr_mask;
  logic            cfg_en;

  // edge detection on the synchronized level
  assign rise = pin_lvl & ~prev_q;
  assign fall = ~pin_lvl & prev_q;
  assign hit  = {PINS{blk_en}} & ien_q & ((edge_q & rise) | (~edge_q & fall));

  assign cfg_en   = wr_en && (reg_sel != RG_EVENT) && (reg_sel != RG_DIN);
  assign clr_mask = (wr_en && reg_sel == RG_EVENT) ? wdata[PINS-1:0] : '0;

  always_comb begin
    mode_d    = mode_q;
    dout_d    = dout_q;
    pulloff_d = pulloff_q;
    ien_d     = ien_q;
    edge_d    = edge_q;
    force_d   = force_q;
    case (reg_sel)
      RG_MODE:    mode_d    = wdata;
      RG_DOUT:    dout_d    = wdata[PINS-1:0];
      RG_PULLOFF: pulloff_d = wdata[PINS-1:0];
      RG_IEN:     ien_d     = wdata[PINS-1:0];
      RG_EDGE:    edge_d    = wdata[PINS-1:0];
      RG_FORCE:   force_d   = wdata[PINS-1:0];
      default: ;
    endcase
    // a new edge wins over a same-cycle clear
    ev_d = (ev_q & ~clr_mask) | hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q    <= '0;
      dout_q    <= '0;
      pulloff_q <= '0;
      ien_q     <= '0;
      edge_q    <= '0;
      force_q   <= '0;
    end else if (cfg_en) begin
      mode_q    <= mode_d;
      dout_q    <= dout_d;
      pulloff_q <= pulloff_d;
      ien_q     <= ien_d;
      edge_q    <= edge_d;
      force_q   <= force_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ev_q   <= '0;
      prev_q <= '0;
    end else begin
      ev_q   <= ev_d;
      prev_q <= pin_lvl;
    end
  end

  // pad drive per pin
  for (genvar n = 0; n < PINS; n++) begin : g_drive
    pin_mode_e m;
    assign m = pin_mode_e'(mode_q[2*n +: 2]);
    always_comb begin
      case (m)
        PM_PUSH:   begin pad_oe[n] = 1'b1;       pad_out[n] = dout_q[n]; end
        PM_SINK:   begin pad_oe[n] = ~dout_q[n]; pad_out[n] = 1'b0;      end
        PM_SOURCE: begin pad_oe[n] = dout_q[n];  pad_out[n] = 1'b1;      end
        default:   begin pad_oe[n] = 1'b0;       pad_out[n] = 1'b0;      end
      endcase
    end
  end

  assign pad_pull_en = ~pulloff_q;
  assign force_any   = |force_q;
  assign irq         = blk_en & ((|(ev_q & ien_q)) | force_any);

  always_comb begin
    case (reg_sel)
      RG_MODE:    rd_val = mode_q;
      RG_DOUT:    rd_val = MW'(dout_q);
      RG_DIN:     rd_val = MW'(pin_lvl);
      RG_PULLOFF: rd_val = MW'(pulloff_q);
      RG_IEN:     rd_val = MW'(ien_q);
      RG_EDGE:    rd_val = MW'(edge_q);
      RG_EVENT:   rd_val = MW'(ev_q);
      default:    rd_val = MW'(force_q);
    endcase
  end
endmodule

// File: rtl/pinbank_ctrl.sv
module pinbank_ctrl
  import pinbank_pkg::*;
#(
  parameter int NUM_PORTS     = 3,
  parameter int ADDR_W        = 8,
  parameter int PORT_BASE     = 16,
  parameter int STRIDE_LOG2   = 4,
  parameter int BLOCK_VERSION = 5,
  parameter int CORE_COUNT    = 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [ADDR_W-1:0]      bus_addr,
  input  logic                   bus_we,
  input  logic [15:0]            bus_wdata,
  output logic [15:0]            bus_rdata,
  input  logic [NUM_PORTS*8-1:0] pad_in,
  output logic [NUM_PORTS*8-1:0] pad_out,
  output logic [NUM_PORTS*8-1:0] pad_oe,
  output logic [NUM_PORTS*8-1:0] pad_pull_en,
  output logic [NUM_PORTS-1:0]   irq
);
  localparam int PINS   = 8;
  localparam int NPIN   = NUM_PORTS * PINS;
  localparam int PIDX_W = ADDR_W - STRIDE_LOG2;

  logic                   blk_en_q, blk_en_d;
  logic [NPIN-1:0]        lvl_sync;
  logic [ADDR_W-1:0]      rel;
  logic [PIDX_W-1:0]      pidx;
  logic [STRIDE_LOG2-1:0] off;
  logic                   port_hit, ctrl_hit;
  port_reg_e              reg_sel;
  logic [15:0]            rd_d;
  logic [15:0]            port_rd [NUM_PORTS];
  logic [NUM_PORTS-1:0]   port_we;
  logic [NUM_PORTS-1:0]   force_any;
  logic [NPIN-1:0]        ev_all, ien_all;

  pinbank_sync #(.W(NPIN)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pad_in), .q(lvl_sync)
  );

  // address decode
  assign rel      = bus_addr - ADDR_W'(PORT_BASE);
  assign pidx     = rel[ADDR_W-1:STRIDE_LOG2];
  assign off      = rel[STRIDE_LOG2-1:0];
  assign ctrl_hit = (bus_addr == '0);
  assign port_hit = (bus_addr >= ADDR_W'(PORT_BASE)) && (int'(pidx) < NUM_PORTS) && (int'(off) < 8);
  assign reg_sel  = port_reg_e'(off[2:0]);

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    assign port_we[p] = bus_we && port_hit && (pidx == PIDX_W'(p));
    pinbank_port #(.PINS(PINS)) u_port (
      .clk         (clk),
      .rst_n       (rst_n),
      .blk_en      (blk_en_q),
      .wr_en       (port_we[p]),
      .reg_sel     (reg_sel),
      .wdata       (bus_wdata),
      .pin_lvl     (lvl_sync[p*PINS +: PINS]),
      .rd_val      (port_rd[p]),
      .pad_out     (pad_out[p*PINS +: PINS]),
      .pad_oe      (pad_oe[p*PINS +: PINS]),
      .pad_pull_en (pad_pull_en[p*PINS +: PINS]),
      .ev_q        (ev_all[p*PINS +: PINS]),
      .ien_q       (ien_all[p*PINS +: PINS]),
      .irq         (irq[p]),
      .force_any   (force_any[p])
    );
  end

  // global control: only the enable bit is writable
  always_comb begin
    blk_en_d = blk_en_q;
    if (bus_we && ctrl_hit) blk_en_d = bus_wdata[0];
  end

  always_comb begin
    rd_d = '0;
    if (ctrl_hit) begin
      rd_d = {7'(BLOCK_VERSION), 7'(CORE_COUNT), 1'b0, blk_en_q};
    end else if (port_hit) begin
      for (int p = 0; p < NUM_PORTS; p++)
        if (pidx == PIDX_W'(p)) rd_d = port_rd[p];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blk_en_q  <= 1'b0;
      bus_rdata <= '0;
    end else begin
      blk_en_q  <= blk_en_d;
      bus_rdata <= rd_d;
    end
  end
endmodule

// File: rtl/pinbank_ctrl_chk.sv
module pinbank_ctrl_chk #(
  parameter int NUM_PORTS     = 3,
  parameter int ADDR_W        = 8,
  parameter int BLOCK_VERSION = 5,
  parameter int CORE_COUNT    = 1
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   blk_en_q,
  input logic [ADDR_W-1:0]      bus_addr,
  input logic [15:0]            bus_rdata,
  input logic [NUM_PORTS-1:0]   irq,
  input logic [NUM_PORTS-1:0]   force_any,
  input logic [NUM_PORTS*8-1:0] ev_all,
  input logic [NUM_PORTS*8-1:0] ien_all
);
  // R14: interrupts silent while the block is off
  p_irq_off_r14: assert property (@(posedge clk) disable iff (!rst_n)
    !blk_en_q |-> (irq == '0));

  // R14: no event latches in a cycle following a disabled one
  p_no_event_off_r14: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(blk_en_q) |-> ((ev_all & ~$past(ev_all)) == '0));

  // R10: a newly set event bit must have been enabled
  p_event_src_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ((ev_all & ~$past(ev_all) & ~$past(ien_all)) == '0));

  // R12: a forced port always shows its interrupt while enabled
  p_force_irq_r12: assert property (@(posedge clk) disable iff (!rst_n)
    ((force_any & {NUM_PORTS{blk_en_q}} & ~irq) == '0));

  // R14: read-only identity fields
  p_ctrl_id_r14: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == '0) |=> (bus_rdata[15:2] == {7'(BLOCK_VERSION), 7'(CORE_COUNT)}));
endmodule

bind pinbank_ctrl pinbank_ctrl_chk #(
  .NUM_PORTS(NUM_PORTS), .ADDR_W(ADDR_W),
  .BLOCK_VERSION(BLOCK_VERSION), .CORE_COUNT(CORE_COUNT)
) chk (
  .clk(clk), .rst_n(rst_n), .blk_en_q(blk_en_q), .bus_addr(bus_addr),
  .bus_rdata(bus_rdata), .irq(irq), .force_any(force_any),
  .ev_all(ev_all), .ien_all(ien_all)
);

// File: tb/pinbank_ctrl_test.sv
module pinbank_ctrl_test;
  localparam int NP = 3;
  localparam int NPIN = NP * 8;

  logic            clk = 1'b0;
  logic            rst_n;
  logic [7:0]      bus_addr;
  logic            bus_we;
  logic [15:0]     bus_wdata;
  logic [15:0]     bus_rdata;
  logic [NPIN-1:0] pad_in, pad_out, pad_oe, pad_pull_en;
  logic [NP-1:0]   irq;

  int checks = 0;
  int fails  = 0;
  logic          rd_issue = 1'b0;
  logic          rd_due = 1'b0;
  logic [15:0]   exp_q[$];
  string         tag_q[$];

  always #4 clk = ~clk;

  pinbank_ctrl uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .pad_pull_en(pad_pull_en), .irq(irq)
  );

  function automatic logic [7:0] preg(int p, int o);
    return 8'(16 + 16 * p + o);
  endfunction

  task automatic wr(logic [7:0] a, logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  // driver: issue a read and push the expected value to the scoreboard
  task automatic rd(logic [7:0] a, logic [15:0] e, string tag);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b0; rd_issue = 1'b1;
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk);
    rd_issue = 1'b0;
  endtask

  task automatic chk(string tag, logic [31:0] act, logic [31:0] e);
    checks++;
    if (act !== e) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, e);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: compare read data one cycle after each issued read
  always @(posedge clk) rd_due <= rd_issue;
  always @(negedge clk) begin
    if (rd_due && exp_q.size() > 0) begin
      logic [15:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      chk(t, 32'(bus_rdata), 32'(e));
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; bus_addr = '0; bus_we = 1'b0; bus_wdata = '0; pad_in = '0;
    idle(3);
    rst_n = 1'b1;
    idle(1);
    // R1 reset state
    chk("R1 pad_oe", 32'(pad_oe), 0);
    chk("R1 pad_out", 32'(pad_out), 0);
    chk("R1 pull", 32'(pad_pull_en), 32'hFFFFFF);
    chk("R1 irq", 32'(irq), 0);
    rd(preg(1, 0), 16'h0000, "R1 mode reset");
    rd(8'h00, 16'h0A04, "R1 ctrl reset");
    // R14 read-only identity fields, enable bit
    wr(8'h00, 16'hFFFF);
    rd(8'h00, 16'h0A05, "R14 ctrl ro fields");
    // R2 decode and pin numbering, R4 push-pull
    wr(preg(1, 1), 16'h00A5);
    rd(preg(1, 1), 16'h00A5, "R2 dout p1");
    rd(preg(2, 1), 16'h0000, "R2 dout p2 untouched");
    wr(preg(1, 0), 16'h5555);
    idle(1);
    chk("R4 push out", 32'(pad_out), 32'h00A500);
    chk("R4 push oe", 32'(pad_oe), 32'h00FF00);
    // R3 pin 0 of port 1 back to input
    wr(preg(1, 0), 16'h5554);
    idle(1);
    chk("R3 input oe", 32'(pad_oe), 32'h00FE00);
    chk("R3 input out", 32'(pad_out), 32'h00A400);
    // R5 sink-only on port 0
    wr(preg(0, 1), 16'h000F);
    wr(preg(0, 0), 16'hAAAA);
    idle(1);
    chk("R5 sink oe", 32'(pad_oe[7:0]), 32'hF0);
    chk("R5 sink out", 32'(pad_out[7:0]), 32'h00);
    // R6 source-only
    wr(preg(0, 0), 16'hFFFF);
    idle(1);
    chk("R6 source oe", 32'(pad_oe[7:0]), 32'h0F);
    chk("R6 source out", 32'(pad_out[7:0]), 32'hFF);
    wr(preg(0, 0), 16'h0000);
    // R13 pull-off
    wr(preg(2, 3), 16'h0081);
    idle(1);
    chk("R13 pull", 32'(pad_pull_en[23:16]), 32'h7E);
    // R7 input sampling
    @(negedge clk); pad_in[23:16] = 8'h3C;
    idle(4);
    rd(preg(2, 2), 16'h003C, "R7 din");
    // R8 rising edge on port 0 pin 0
    wr(preg(0, 4), 16'h0003);
    wr(preg(0, 5), 16'h0001);
    @(negedge clk); pad_in[0] = 1'b1;
    idle(5);
    chk("R8 irq rise", 32'(irq), 32'h1);
    rd(preg(0, 6), 16'h0001, "R8 event rise");
    wr(preg(0, 6), 16'h0001);
    idle(1);
    chk("R11 irq cleared", 32'(irq), 0);
    @(negedge clk); pad_in[0] = 1'b0;
    idle(5);
    rd(preg(0, 6), 16'h0000, "R8 falling ignored");
    chk("R8 irq falling ignored", 32'(irq), 0);
    // R9 falling edge on pin 1
    @(negedge clk); pad_in[1] = 1'b1;
    idle(5);
    rd(preg(0, 6), 16'h0000, "R9 rising ignored");
    @(negedge clk); pad_in[1] = 1'b0;
    idle(5);
    rd(preg(0, 6), 16'h0002, "R9 event fall");
    chk("R9 irq fall", 32'(irq), 32'h1);
    // R11 write-one-to-clear selectivity
    @(negedge clk); pad_in[0] = 1'b1;
    idle(5);
    rd(preg(0, 6), 16'h0003, "R11 two events");
    wr(preg(0, 6), 16'h0001);
    rd(preg(0, 6), 16'h0002, "R11 clear one bit");
    wr(preg(0, 6), 16'h0000);
    rd(preg(0, 6), 16'h0002, "R11 zero write no effect");
    wr(preg(0, 6), 16'h0002);
    rd(preg(0, 6), 16'h0000, "R11 all clear");
    chk("R11 irq low", 32'(irq), 0);
    // R10 disabled pin 2
    @(negedge clk); pad_in[2] = 1'b1;
    idle(5);
    @(negedge clk); pad_in[2] = 1'b0;
    idle(5);
    rd(preg(0, 6), 16'h0000, "R10 disabled pin");
    chk("R10 irq", 32'(irq), 0);
    // R12 force
    wr(preg(1, 7), 16'h0001);
    idle(1);
    chk("R12 forced", 32'(irq), 32'h2);
    wr(preg(1, 7), 16'h0000);
    idle(1);
    chk("R12 unforced", 32'(irq), 0);
    // R14 block off
    wr(preg(1, 7), 16'h0001);
    wr(8'h00, 16'h0000);
    idle(1);
    chk("R14 irq off", 32'(irq), 0);
    rd(8'h00, 16'h0A04, "R14 ctrl off");
    @(negedge clk); pad_in[0] = 1'b0;
    idle(5);
    @(negedge clk); pad_in[0] = 1'b1;
    idle(5);
    rd(preg(0, 6), 16'h0000, "R14 no event when off");
    wr(8'h00, 16'h0001);
    idle(1);
    chk("R14 force back on", 32'(irq), 32'h2);
    idle(3);
    chk("R14 scoreboard drained", 32'(exp_q.size()), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule